// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the command front end on the device side of a small-page NAND flash memory. It watches the 8-bit I/O bus, the command and address latch enables, the write strobe, the chip select and the write-protect pin. It captures bytes on rising edges of the write strobe and decodes one-, two- and three-step command sequences. It also collects the column and row address from the address cycles. The results are single-cycle operation strobes for the array controller, together with the latched address and the current area pointer.

The read pointer selects the first half-page, the second half-page or the spare area. A read command sets it, and the pointer supplies the address bit that the bus never carries. Program, erase and copy-back act only after a separate confirm byte. While the array reports busy, only status and reset get through. Write protect is sampled at the moment a confirm is decoded and is never held. A status byte collects the write-protect level, the ready state and a pass/fail flag, and it is refreshed each time a status read is decoded. The parameter `LARGE_DEV` picks between a three-cycle address and a four-cycle address.

Top module: `nand_cmd_if`

## Requirements
- R1: A byte is taken only on a rising edge of `wr_strobe_ni` while `chip_sel_ni` is low. It is a command when `cmd_latch_i` is high and `addr_latch_i` is low, and an address when the two are the other way round. Every other combination is ignored.
- R2: Commands 0x00, 0x01 and 0x50 set `area_o` to 0, 1 and 2. `half_o` is high only for area 1. `rd_o` pulses on the last required address cycle that follows one of these commands.
- R3: The first address cycle loads `col_o`. The next cycles load `row_o` one byte at a time, least significant byte first. With `LARGE_DEV`=1 there are four cycles, and the fourth cycle adds only I/O bits 1:0 as row bits 17:16. With `LARGE_DEV`=0 there are three cycles and a 16-bit row.
- R4: Address cycles beyond the required count, or any that arrive with no address-taking command pending, leave `col_o` and `row_o` unchanged and raise no strobe.
- R5: 0x80, then the full address, then 0x10 pulses `prog_o` for one cycle.
- R6: 0x60, then the row cycles only (no column), then 0xD0 pulses `erase_o` and loads `row_o` from those cycles.
- R7: 0x8A is accepted only right after a completed 0x00 read, and then takes a full address. A following 0x10 pulses `cpbk_o`. Any other 0x8A is dropped.
- R8: A confirm byte with no matching setup, a confirm that arrives before the address is complete, a wrong confirm, or an undefined byte returns the sequencer to idle with no strobe.
- R9: While `busy_i` is high, only 0x70 and 0xFF are accepted. All other commands and all address cycles are dropped without any change of state.
- R10: If `wr_prot_ni` is low at the moment a program, erase or copy-back confirm is decoded, no strobe is raised and the fail flag is set. The level at setup time does not matter.
- R11: 0x70 pulses `rd_stat_o` and loads `status_o` = {`wr_prot_ni`, not `busy_i`, 5'b0, fail}. `op_done_i` loads fail from `op_fail_i`. An accepted program, erase or copy-back strobe clears fail.
- R12: 0xFF pulses `reset_o`, abandons any sequence in progress, sets `area_o` to 0 and clears fail.
- R13: 0x90 pulses `rd_id_o`.
- R14: The strobes are registered and appear one cycle after the decoding edge. At most one strobe is high in any cycle, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_i | input | 8 | I/O bus byte |
| cmd_latch_i | input | 1 | Marks the bus byte as a command |
| addr_latch_i | input | 1 | Marks the bus byte as an address |
| wr_strobe_ni | input | 1 | Write strobe, active low, byte taken on its rise |
| chip_sel_ni | input | 1 | Chip select, active low |
| wr_prot_ni | input | 1 | Write protect, active low |
| busy_i | input | 1 | Array busy |
| op_done_i | input | 1 | Array operation finished |
| op_fail_i | input | 1 | Result of the finished operation (1 = fail) |
| rd_o | output | 1 | Page read strobe |
| rd_id_o | output | 1 | Signature read strobe |
| rd_stat_o | output | 1 | Status read strobe |
| prog_o | output | 1 | Page program strobe |
| cpbk_o | output | 1 | Copy-back program strobe |
| erase_o | output | 1 | Block erase strobe |
| reset_o | output | 1 | Reset strobe |
| col_o | output | 8 | Column address |
| row_o | output | 16 or 18 | Row address |
| half_o | output | 1 | Half-page address bit taken from the pointer |
| area_o | output | 2 | Area pointer: 0 first half, 1 second half, 2 spare |
| status_o | output | 8 | Status byte |

## Verification
The assertions assume that `wr_strobe_ni`, `io_i` and the latch enables are synchronous to `clk_i`. They also assume that the write strobe stays low for at least one clock edge, so that each bus write produces exactly one decoding edge. `busy_i` and `wr_prot_ni` are taken as static around that edge. The bench drives every input on the falling clock edge and holds the strobe low for a full cycle before releasing it. It changes busy and write protect only between bus writes. This way each command or address byte maps to exactly one rising edge at which the strobe and address results can be predicted.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  typedef enum logic [1:0] {
    AREA_LO    = 2'd0,
    AREA_HI    = 2'd1,
    AREA_SPARE = 2'd2
  } area_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_PG_ADDR,
    ST_ER_ADDR,
    ST_CB_ADDR
  } seq_e;

  typedef struct packed {
    logic rd;
    logic rd_id;
    logic rd_stat;
    logic prog;
    logic cpbk;
    logic erase;
    logic rst;
  } strobe_t;

  localparam logic [7:0] OP_READ_LO  = 8'h00;
  localparam logic [7:0] OP_READ_HI  = 8'h01;
  localparam logic [7:0] OP_READ_SP  = 8'h50;
  localparam logic [7:0] OP_SIG      = 8'h90;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_RESET    = 8'hFF;
  localparam logic [7:0] OP_PROG     = 8'h80;
  localparam logic [7:0] OP_PROG_GO  = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h60;
  localparam logic [7:0] OP_ERASE_GO = 8'hD0;
  localparam logic [7:0] OP_CPBK     = 8'h8A;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] io_i,
  input  logic       cmd_latch_i,
  input  logic       addr_latch_i,
  input  logic       wr_strobe_ni,
  input  logic       chip_sel_ni,
  output logic       cmd_ev_o,
  output logic       addr_ev_o,
  output logic [7:0] byte_o
);

  logic we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= wr_strobe_ni;
  end

  logic rise;
  assign rise      = ~we_q & wr_strobe_ni & ~chip_sel_ni;
  assign cmd_ev_o  = rise & cmd_latch_i & ~addr_latch_i;
  assign addr_ev_o = rise & addr_latch_i & ~cmd_latch_i;
  assign byte_o    = io_i;

endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
  parameter int ADDR_CYCLES = 3,
  parameter int ROW_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             skip_col_i,
  input  logic             wr_i,
  input  logic [7:0]       byte_i,
  output logic [7:0]       col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             last_o,
  output logic             done_o
);

  localparam int         ROW_BYTES = ADDR_CYCLES - 1;
  localparam logic [2:0] NCYC      = 3'(ADDR_CYCLES);

  logic [2:0] cnt_q;
  logic       skip_q;
  logic [2:0] target;
  logic [2:0] slot;
  logic       take;

  assign target = NCYC - {2'b00, skip_q};
  assign slot   = cnt_q + {2'b00, skip_q};
  assign take   = wr_i & (cnt_q < target);
  assign last_o = take & (cnt_q == target - 3'd1);
  assign done_o = (cnt_q == target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      skip_q <= skip_col_i;
    end else if (take) begin
      cnt_q  <= cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        col_o <= '0;
    else if (take && slot == 3'd0)      col_o <= byte_i;
  end

  for (genvar j = 0; j < ROW_BYTES; j++) begin : g_row
    localparam int W = (j == ROW_BYTES - 1) ? ROW_W - 8 * j : 8;
    logic [W-1:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          b_q <= '0;
      else if (take && slot == 3'(j + 1))   b_q <= byte_i[W-1:0];
    end
    assign row_o[8*j +: W] = b_q;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= target); // R4

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_ev_i,
  input  logic       addr_ev_i,
  input  logic [7:0] byte_i,
  input  logic       busy_i,
  input  logic       wp_ni,
  input  logic       op_done_i,
  input  logic       op_fail_i,
  input  logic       addr_last_i,
  input  logic       addr_done_i,
  output strobe_t    strobe_o,
  output area_e      area_o,
  output logic       addr_start_o,
  output logic       addr_skip_o,
  output logic       addr_wr_o,
  output logic [7:0] status_o
);

  seq_e    state_q, state_n;
  area_e   area_q, area_n;
  strobe_t stb_q, stb_n;
  logic    cb_arm_q, cb_arm_n;
  logic    fail_q, fail_n;
  logic [7:0] stat_q, stat_n;
  logic    acc;

  assign acc = cmd_ev_i & (~busy_i | byte_i == OP_STAT | byte_i == OP_RESET);
  assign addr_wr_o = addr_ev_i & ~busy_i & (state_q != ST_IDLE);

  always_comb begin
    state_n      = state_q;
    area_n       = area_q;
    stb_n        = '0;
    cb_arm_n     = cb_arm_q;
    fail_n       = fail_q;
    stat_n       = stat_q;
    addr_start_o = 1'b0;
    addr_skip_o  = 1'b0;
    if (op_done_i) fail_n = op_fail_i;
    if (acc) begin
      if (byte_i != OP_STAT) cb_arm_n = 1'b0;
      case (byte_i)
        OP_READ_LO, OP_READ_HI, OP_READ_SP: begin
          area_n = (byte_i == OP_READ_LO) ? AREA_LO :
                   (byte_i == OP_READ_HI) ? AREA_HI : AREA_SPARE;
          state_n      = ST_RD_ADDR;
          addr_start_o = 1'b1;
        end
        OP_PROG: begin
          state_n      = ST_PG_ADDR;
          addr_start_o = 1'b1;
        end
        OP_ERASE: begin
          state_n      = ST_ER_ADDR;
          addr_start_o = 1'b1;
          addr_skip_o  = 1'b1;
        end
        OP_CPBK: begin
          if (cb_arm_q) begin
            state_n      = ST_CB_ADDR;
            addr_start_o = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end
        OP_SIG: begin
          stb_n.rd_id = 1'b1;
          state_n     = ST_IDLE;
        end
        OP_STAT: begin
          stb_n.rd_stat = 1'b1;
          stat_n        = {wp_ni, ~busy_i, 5'b0, fail_q};
        end
        OP_RESET: begin
          stb_n.rst = 1'b1;
          state_n   = ST_IDLE;
          area_n    = AREA_LO;
          fail_n    = 1'b0;
        end
        OP_PROG_GO: begin
          state_n = ST_IDLE;
          if (addr_done_i && (state_q == ST_PG_ADDR || state_q == ST_CB_ADDR)) begin
            if (wp_ni) begin
              stb_n.prog = (state_q == ST_PG_ADDR);
              stb_n.cpbk = (state_q == ST_CB_ADDR);
              fail_n     = 1'b0;
            end else begin
              fail_n = 1'b1;
            end
          end
        end
        OP_ERASE_GO: begin
          state_n = ST_IDLE;
          if (addr_done_i && state_q == ST_ER_ADDR) begin
            if (wp_ni) begin
              stb_n.erase = 1'b1;
              fail_n      = 1'b0;
            end else begin
              fail_n = 1'b1;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end else if (addr_wr_o && addr_last_i && state_q == ST_RD_ADDR) begin
      stb_n.rd = 1'b1;
      state_n  = ST_IDLE;
      cb_arm_n = (area_q == AREA_LO);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      area_q   <= AREA_LO;
      stb_q    <= '0;
      cb_arm_q <= 1'b0;
      fail_q   <= 1'b0;
      stat_q   <= '0;
    end else begin
      state_q  <= state_n;
      area_q   <= area_n;
      stb_q    <= stb_n;
      cb_arm_q <= cb_arm_n;
      fail_q   <= fail_n;
      stat_q   <= stat_n;
    end
  end

  assign strobe_o = stb_q;
  assign area_o   = area_q;
  assign status_o = stat_q;

  AST_STB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_q)); // R14
  AST_WP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q.prog || stb_q.cpbk || stb_q.erase) |-> $past(wp_ni)); // R10
  AST_BUSY_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q.rd || stb_q.rd_id || stb_q.prog || stb_q.cpbk || stb_q.erase) |-> !$past(busy_i)); // R9
  AST_PROG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q.prog |=> !stb_q.prog); // R5
  AST_AREA_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    area_q != 2'd3); // R2
  AST_RST_AREA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q.rst |-> area_q == AREA_LO); // R12

endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
  import nand_cmd_pkg::*;
#(
  parameter bit LARGE_DEV = 1'b0,
  localparam int ADDR_CYCLES = LARGE_DEV ? 4 : 3,
  localparam int ROW_W       = LARGE_DEV ? 18 : 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       io_i,
  input  logic             cmd_latch_i,
  input  logic             addr_latch_i,
  input  logic             wr_strobe_ni,
  input  logic             chip_sel_ni,
  input  logic             wr_prot_ni,
  input  logic             busy_i,
  input  logic             op_done_i,
  input  logic             op_fail_i,
  output logic             rd_o,
  output logic             rd_id_o,
  output logic             rd_stat_o,
  output logic             prog_o,
  output logic             cpbk_o,
  output logic             erase_o,
  output logic             reset_o,
  output logic [7:0]       col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             half_o,
  output logic [1:0]       area_o,
  output logic [7:0]       status_o
);

  logic       cmd_ev, addr_ev;
  logic [7:0] bus_byte;
  logic       a_start, a_skip, a_wr, a_last, a_done;
  strobe_t    stb;
  area_e      area;

  nand_bus_sampler u_sampler (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .io_i         (io_i),
    .cmd_latch_i  (cmd_latch_i),
    .addr_latch_i (addr_latch_i),
    .wr_strobe_ni (wr_strobe_ni),
    .chip_sel_ni  (chip_sel_ni),
    .cmd_ev_o     (cmd_ev),
    .addr_ev_o    (addr_ev),
    .byte_o       (bus_byte)
  );

  nand_addr_collect #(
    .ADDR_CYCLES (ADDR_CYCLES),
    .ROW_W       (ROW_W)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (a_start),
    .skip_col_i (a_skip),
    .wr_i       (a_wr),
    .byte_i     (bus_byte),
    .col_o      (col_o),
    .row_o      (row_o),
    .last_o     (a_last),
    .done_o     (a_done)
  );

  nand_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_ev_i     (cmd_ev),
    .addr_ev_i    (addr_ev),
    .byte_i       (bus_byte),
    .busy_i       (busy_i),
    .wp_ni        (wr_prot_ni),
    .op_done_i    (op_done_i),
    .op_fail_i    (op_fail_i),
    .addr_last_i  (a_last),
    .addr_done_i  (a_done),
    .strobe_o     (stb),
    .area_o       (area),
    .addr_start_o (a_start),
    .addr_skip_o  (a_skip),
    .addr_wr_o    (a_wr),
    .status_o     (status_o)
  );

  assign rd_o      = stb.rd;
  assign rd_id_o   = stb.rd_id;
  assign rd_stat_o = stb.rd_stat;
  assign prog_o    = stb.prog;
  assign cpbk_o    = stb.cpbk;
  assign erase_o   = stb.erase;
  assign reset_o   = stb.rst;
  assign area_o    = area;
  assign half_o    = (area == AREA_HI);

endmodule

// File: tb/nand_cmd_if_tb.sv
module nand_cmd_if_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  localparam logic [6:0] S_RD = 7'd64, S_ID = 7'd32, S_ST = 7'd16, S_PG = 7'd8,
                         S_CB = 7'd4,  S_ER = 7'd2,  S_RS = 7'd1, S_NO = 7'd0;

  // {is_cmd, byte, expected strobes {rd,id,stat,prog,cpbk,erase,reset}}
  localparam int NV = 36;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 8'h00, S_NO}, {1'b0, 8'h12, S_NO}, {1'b0, 8'h34, S_NO}, {1'b0, 8'h56, S_RD},
    {1'b0, 8'h78, S_NO}, {1'b1, 8'h8A, S_NO}, {1'b0, 8'h00, S_NO}, {1'b0, 8'h11, S_NO},
    {1'b0, 8'h22, S_NO}, {1'b1, 8'h10, S_CB}, {1'b1, 8'h80, S_NO}, {1'b0, 8'h01, S_NO},
    {1'b0, 8'h02, S_NO}, {1'b0, 8'h03, S_NO}, {1'b1, 8'h10, S_PG}, {1'b1, 8'h60, S_NO},
    {1'b0, 8'h04, S_NO}, {1'b0, 8'h05, S_NO}, {1'b1, 8'hD0, S_ER}, {1'b1, 8'h90, S_ID},
    {1'b1, 8'h70, S_ST}, {1'b1, 8'hFF, S_RS}, {1'b1, 8'h10, S_NO}, {1'b1, 8'h80, S_NO},
    {1'b0, 8'h06, S_NO}, {1'b0, 8'h07, S_NO}, {1'b0, 8'h08, S_NO}, {1'b1, 8'hD0, S_NO},
    {1'b1, 8'h10, S_NO}, {1'b1, 8'h8A, S_NO}, {1'b1, 8'h10, S_NO}, {1'b1, 8'h33, S_NO},
    {1'b1, 8'h60, S_NO}, {1'b0, 8'h09, S_NO}, {1'b1, 8'h10, S_NO}, {1'b1, 8'hD0, S_NO}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] io = '0;
  logic cmd_latch = 1'b0, addr_latch = 1'b0, we_n = 1'b1, cs_n = 1'b0;
  logic wp_n = 1'b1, busy = 1'b0, op_done = 1'b0, op_fail = 1'b0;

  logic rd, rd_id, rd_stat, prog, cpbk, erase, rst_s, half;
  logic [7:0] col, status;
  logic [15:0] row;
  logic [1:0] area;
  logic rd_l, rd_id_l, rd_stat_l, prog_l, cpbk_l, erase_l, rst_l, half_l;
  logic [7:0] col_l, status_l;
  logic [17:0] row_l;
  logic [1:0] area_l;

  logic [6:0] stb, stb_l;
  assign stb   = {rd, rd_id, rd_stat, prog, cpbk, erase, rst_s};
  assign stb_l = {rd_l, rd_id_l, rd_stat_l, prog_l, cpbk_l, erase_l, rst_l};

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_cmd_if #(.LARGE_DEV(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_i(io), .cmd_latch_i(cmd_latch),
    .addr_latch_i(addr_latch), .wr_strobe_ni(we_n), .chip_sel_ni(cs_n),
    .wr_prot_ni(wp_n), .busy_i(busy), .op_done_i(op_done), .op_fail_i(op_fail),
    .rd_o(rd), .rd_id_o(rd_id), .rd_stat_o(rd_stat), .prog_o(prog), .cpbk_o(cpbk),
    .erase_o(erase), .reset_o(rst_s), .col_o(col), .row_o(row), .half_o(half),
    .area_o(area), .status_o(status)
  );

  nand_cmd_if #(.LARGE_DEV(1'b1)) dut_l (
    .clk_i(clk), .rst_ni(rst_n), .io_i(io), .cmd_latch_i(cmd_latch),
    .addr_latch_i(addr_latch), .wr_strobe_ni(we_n), .chip_sel_ni(cs_n),
    .wr_prot_ni(wp_n), .busy_i(busy), .op_done_i(op_done), .op_fail_i(op_fail),
    .rd_o(rd_l), .rd_id_o(rd_id_l), .rd_stat_o(rd_stat_l), .prog_o(prog_l), .cpbk_o(cpbk_l),
    .erase_o(erase_l), .reset_o(rst_l), .col_o(col_l), .row_o(row_l), .half_o(half_l),
    .area_o(area_l), .status_o(status_l)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Returns on the falling edge after the decoding edge, where strobes are visible.
  task automatic bus_raw(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    io = b; cmd_latch = c; addr_latch = a; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cmd(input logic [7:0] b);
    bus_raw(1'b1, 1'b0, b);
  endtask

  task automatic wr_addr(input logic [7:0] b);
    bus_raw(1'b0, 1'b1, b);
  endtask

  task automatic addr3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    wr_addr(a); wr_addr(b); wr_addr(c);
  endtask

  task automatic done_pulse(input logic f);
    @(negedge clk);
    op_done = 1'b1; op_fail = f;
    @(negedge clk);
    op_done = 1'b0; op_fail = 1'b0;
  endtask

  function automatic string tag(input logic [6:0] e);
    case (e)
      S_RD: return "R2";
      S_CB: return "R7";
      S_PG: return "R5";
      S_ER: return "R6";
      S_ID: return "R13";
      S_ST: return "R11";
      S_RS: return "R12";
      default: return "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 reset strobes", 32'(stb), 0);
    chk("R2 reset area", 32'(area), 0);
    chk("R11 reset status", 32'(status), 0);

    for (int i = 0; i < NV; i++) begin
      bus_raw(VEC[i][15], ~VEC[i][15], VEC[i][14:7]);
      chk({tag(VEC[i][6:0]), " R14 table"}, 32'(stb), 32'(VEC[i][6:0]));
    end

    // R3, R4: address assembly and overflow
    wr_cmd(8'h00); addr3(8'h12, 8'h34, 8'h56);
    chk("R2 read strobe", 32'(stb), 32'(S_RD));
    chk("R3 column", 32'(col), 32'h12);
    chk("R3 row", 32'(row), 32'h5634);
    chk("R2 half low", 32'(half), 0);
    wr_addr(8'h78);
    chk("R4 extra strobe", 32'(stb), 0);
    chk("R4 column kept", 32'(col), 32'h12);
    chk("R4 row kept", 32'(row), 32'h5634);

    // R2: pointer
    wr_cmd(8'h01);
    chk("R2 area hi", 32'(area), 1);
    chk("R2 half hi", 32'(half), 1);
    addr3(8'h9A, 8'hBC, 8'hDE);
    chk("R2 read hi strobe", 32'(stb), 32'(S_RD));
    chk("R3 column 2", 32'(col), 32'h9A);
    chk("R3 row 2", 32'(row), 32'hDEBC);
    wr_cmd(8'h50);
    chk("R2 area spare", 32'(area), 2);
    chk("R2 half spare", 32'(half), 0);

    // R1: qualification of bus writes
    cs_n = 1'b1;
    wr_cmd(8'h90);
    chk("R1 deselected", 32'(stb), 0);
    cs_n = 1'b0;
    bus_raw(1'b0, 1'b0, 8'h90);
    chk("R1 data cycle", 32'(stb), 0);
    bus_raw(1'b1, 1'b1, 8'h90);
    chk("R1 both latches", 32'(stb), 0);

    // R6: erase takes row cycles only
    wr_cmd(8'h60); wr_addr(8'hAB); wr_addr(8'hCD);
    wr_cmd(8'hD0);
    chk("R6 erase strobe", 32'(stb), 32'(S_ER));
    chk("R6 erase row", 32'(row), 32'hCDAB);
    chk("R6 column kept", 32'(col), 32'h9A);

    // R7: copy-back without preceding read
    wr_cmd(8'h8A); addr3(8'h01, 8'h02, 8'h03);
    wr_cmd(8'h10);
    chk("R7 unarmed copy-back", 32'(stb), 0);

    // R9: busy filtering
    busy = 1'b1;
    wr_cmd(8'h90);
    chk("R9 id dropped", 32'(stb), 0);
    wr_cmd(8'h01); addr3(8'h44, 8'h55, 8'h66);
    chk("R9 read dropped", 32'(stb), 0);
    chk("R9 area unchanged", 32'(area), 2);
    chk("R9 row unchanged", 32'(row), 32'hCDAB);
    wr_cmd(8'h70);
    chk("R9 status accepted", 32'(stb), 32'(S_ST));
    chk("R11 busy status", 32'(status), 32'h80);
    wr_cmd(8'hFF);
    chk("R9 reset accepted", 32'(stb), 32'(S_RS));
    wr_cmd(8'h80);
    busy = 1'b0;
    addr3(8'h01, 8'h02, 8'h03);
    wr_cmd(8'h10);
    chk("R9 setup dropped", 32'(stb), 0);

    // R10: write protect
    wp_n = 1'b0;
    wr_cmd(8'h80); addr3(8'h01, 8'h02, 8'h03);
    wr_cmd(8'h10);
    chk("R10 protected program", 32'(stb), 0);
    wr_cmd(8'h70);
    chk("R10 fail flag", 32'(status), 32'h41);
    wp_n = 1'b1;
    wr_cmd(8'h70);
    chk("R11 wp level live", 32'(status), 32'hC1);
    wp_n = 1'b0;
    wr_cmd(8'h80); addr3(8'h01, 8'h02, 8'h03);
    wp_n = 1'b1;
    wr_cmd(8'h10);
    chk("R10 sampled at confirm", 32'(stb), 32'(S_PG));
    wr_cmd(8'h70);
    chk("R11 fail cleared", 32'(status), 32'hC0);

    // R11: operation result
    done_pulse(1'b1);
    wr_cmd(8'h70);
    chk("R11 op fail", 32'(status), 32'hC1);
    done_pulse(1'b0);
    wr_cmd(8'h70);
    chk("R11 op pass", 32'(status), 32'hC0);

    // R12: reset aborts a sequence
    wr_cmd(8'h50);
    wr_cmd(8'h80); addr3(8'h01, 8'h02, 8'h03);
    wr_cmd(8'hFF);
    chk("R12 reset strobe", 32'(stb), 32'(S_RS));
    chk("R12 area cleared", 32'(area), 0);
    wr_cmd(8'h10);
    chk("R12 sequence aborted", 32'(stb), 0);

    // R13
    wr_cmd(8'h90);
    chk("R13 id strobe", 32'(stb), 32'(S_ID));

    // R8: confirm before address complete
    wr_cmd(8'h80); wr_addr(8'h01);
    wr_cmd(8'h10);
    chk("R8 early confirm", 32'(stb), 0);
    wr_cmd(8'h10);
    chk("R8 idle confirm", 32'(stb), 0);

    // R3: four-cycle device
    wr_cmd(8'hFF);
    wr_cmd(8'h00); addr3(8'h01, 8'h02, 8'h03);
    chk("R3 small read at 3", 32'(stb), 32'(S_RD));
    chk("R3 large waits", 32'(stb_l), 0);
    wr_addr(8'hFF);
    chk("R3 large read at 4", 32'(stb_l), 32'(S_RD));
    chk("R3 large row", 32'(row_l), 32'h30302);
    chk("R3 large column", 32'(col_l), 32'h01);
    chk("R4 small ignores 4th", 32'(stb), 0);
    wr_addr(8'h08);
    chk("R4 large extra", 32'(stb_l), 0);
    chk("R4 large row kept", 32'(row_l), 32'h30302);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule